// File: doc/BRIEF.md
# Outbound Message Interrupt Status Controller

This block holds the interrupt status and mask words for events that a local processor raises toward a host. There are four event sources. Two message events are latched and cleared by the host. A doorbell pending level is mirrored directly. A post-queue condition stays set while an internal queue of frame addresses is not empty. The local side pushes 32-bit frame addresses into that queue, and the host pops them one at a time by reading a dedicated port.

The host reaches the block through a simple single-cycle register port with three selects: status, mask and post queue. Read data is registered and appears one clock after the read strobe. The block drives one registered interrupt line. This line is high when any event is pending and its mask bit is clear. A separate one-cycle pulse reports a push that arrived while the queue was full and was therefore dropped.

Top module: `omsg_irq_ctrl`

## Requirements
- R1: After reset, reads of the status select (host_sel=0) and the mask select (host_sel=1) return 0, and irq_out is 0.
- R2: A pulse on loc_msg_set[0] or loc_msg_set[1] sets status bit 0 or bit 1 and the bit stays set. Writing status with a 1 at that position clears it. Writing a 0 there leaves it unchanged.
- R3: If a message set and a host write-1-to-clear reach the same status bit in the same cycle, the bit ends up set.
- R4: Status bit 3 reads as the level of loc_db_pend in the cycle of the read. Host writes to status do not change it.
- R5: Status bit 5 is 1 while the post queue holds at least one entry. A host write to status does not change it. It returns to 0 once the last entry has been read from the post-queue select (host_sel=2).
- R6: While mask bit 5 is set, status bit 5 reads as 0 even when entries are queued. Once mask bit 5 is cleared, the pending value reads back as 1.
- R7: A write to the mask select stores only bits 5, 3, 1 and 0. All other bits of both the mask word and the status word read as 0.
- R8: The post queue holds 8 entries and returns them in push order, one per read of host_sel=2. A read while the queue is empty returns 32'hFFFF_FFFF.
- R9: A push while the queue holds 8 entries, with no pop in the same cycle, is dropped. ovf_out is then high for exactly one cycle, in the cycle after that push.
- R10: irq_out goes high one cycle after any status bit (raw, before masking) is set while its mask bit is clear. It falls one cycle after the mask blocks every pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_en | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_sel | input | 2 | 0 status, 1 mask, 2 post queue, 3 unused |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered read data, valid the cycle after a read |
| loc_msg_set | input | 2 | One-cycle set pulses for message events 0 and 1 |
| loc_db_pend | input | 1 | Level: an outbound doorbell is pending |
| loc_push | input | 1 | Push a frame address into the post queue |
| loc_push_data | input | 32 | Frame address to push |
| irq_out | output | 1 | Registered interrupt request |
| ovf_out | output | 1 | One-cycle pulse for a dropped push |

## Verification
Most wrong internal state becomes visible at a status read one clock after the access. A stuck message bit, a lost set, or a post-queue bit that ignores the queue fill all show up there. A bad mask bit shows up on irq_out, which trails the cause by exactly one cycle, so the bench samples that line in both the cycle before and the cycle after the expected change. Queue pointer or count errors only appear after a full fill and drain. They show up as values returned out of order, a missing overflow pulse, or a post-queue bit that clears too early or never clears.

// File: rtl/omsg_irq_pkg.sv
package omsg_irq_pkg;
  localparam int REG_W   = 32;
  localparam int N_MSG   = 2;
  localparam int B_MSG0  = 0;
  localparam int B_MSG1  = 1;
  localparam int B_DB    = 3;
  localparam int B_PQ    = 5;
  localparam logic [REG_W-1:0] EVT_BITS =
    (REG_W'(1) << B_PQ) | (REG_W'(1) << B_DB) |
    (REG_W'(1) << B_MSG1) | (REG_W'(1) << B_MSG0);

  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_MASK = 2'd1,
    SEL_POST = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;
endpackage

// File: rtl/omsg_rst_sync.sv
module omsg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/omsg_msg_bits.sv
module omsg_msg_bits #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q, d;

    // a set in the same cycle as a clear wins
    always_comb begin
      d = q;
      if (clr_i[i]) d = 1'b0;
      if (set_i[i]) d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= d;
    end

    assign q_o[i] = q;
  end
endmodule

// File: rtl/omsg_post_fifo.sv
module omsg_post_fifo #(
  parameter int DEPTH = 8,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] pop_data_o,
  output logic          nonempty_o,
  output logic          full_o,
  output logic          drop_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign nonempty_o = (cnt_q != '0);
  assign full_o     = (cnt_q == CW'(DEPTH));
  assign do_pop     = pop_i & nonempty_o;
  assign do_push    = push_i & (~full_o | do_pop);
  assign drop_o     = push_i & full_o & ~do_pop;
  assign pop_data_o = nonempty_o ? mem[rd_q] : '1;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = (wr_q == LAST) ? '0 : wr_q + AW'(1);
    if (do_pop)  rd_d = (rd_q == LAST) ? '0 : rd_q + AW'(1);
    if (do_push && !do_pop)      cnt_d = cnt_q + CW'(1);
    else if (do_pop && !do_push) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  // storage carries no reset; the count guards every read
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= push_data_i;
  end
endmodule

// File: rtl/omsg_irq_ctrl.sv
module omsg_irq_ctrl
  import omsg_irq_pkg::*;
#(
  parameter int POST_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_en,
  input  logic             host_we,
  input  logic [1:0]       host_sel,
  input  logic [REG_W-1:0] host_wdata,
  output logic [REG_W-1:0] host_rdata,
  input  logic [N_MSG-1:0] loc_msg_set,
  input  logic             loc_db_pend,
  input  logic             loc_push,
  input  logic [REG_W-1:0] loc_push_data,
  output logic             irq_out,
  output logic             ovf_out
);
  logic             rst_sn;
  logic             wr_stat, wr_mask, rd_any, pop;
  logic [N_MSG-1:0] msg_clr, msg_q;
  logic [REG_W-1:0] pop_data, raw_stat, vis_stat, mask_q, mask_d, rdata_d;
  logic             pq_pend, pq_full, drop, irq_d;

  omsg_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  assign wr_stat = host_en & host_we  & (host_sel == SEL_STAT);
  assign wr_mask = host_en & host_we  & (host_sel == SEL_MASK);
  assign rd_any  = host_en & ~host_we;
  assign pop     = rd_any & (host_sel == SEL_POST);

  always_comb begin
    msg_clr = '0;
    msg_clr[0] = wr_stat & host_wdata[B_MSG0];
    msg_clr[1] = wr_stat & host_wdata[B_MSG1];
  end

  omsg_msg_bits #(.N(N_MSG)) u_msg (
    .clk(clk), .rst_n(rst_sn), .set_i(loc_msg_set), .clr_i(msg_clr), .q_o(msg_q)
  );

  omsg_post_fifo #(.DEPTH(POST_DEPTH), .DW(REG_W)) u_fifo (
    .clk(clk), .rst_n(rst_sn),
    .push_i(loc_push), .push_data_i(loc_push_data), .pop_i(pop),
    .pop_data_o(pop_data), .nonempty_o(pq_pend), .full_o(pq_full), .drop_o(drop)
  );

  always_comb begin
    raw_stat         = '0;
    raw_stat[B_PQ]   = pq_pend;
    raw_stat[B_DB]   = loc_db_pend;
    raw_stat[B_MSG1] = msg_q[1];
    raw_stat[B_MSG0] = msg_q[0];
    vis_stat         = raw_stat;
    vis_stat[B_PQ]   = pq_pend & ~mask_q[B_PQ];
  end

  always_comb begin
    mask_d = mask_q;
    if (wr_mask) mask_d = host_wdata & EVT_BITS;
  end

  always_comb begin
    rdata_d = host_rdata;
    if (rd_any) begin
      case (host_sel)
        SEL_STAT: rdata_d = vis_stat;
        SEL_MASK: rdata_d = mask_q;
        SEL_POST: rdata_d = pop_data;
        default:  rdata_d = '0;
      endcase
    end
  end

  assign irq_d = |(raw_stat & ~mask_q);

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      mask_q     <= '0;
      host_rdata <= '0;
      irq_out    <= 1'b0;
      ovf_out    <= 1'b0;
    end else begin
      mask_q     <= mask_d;
      host_rdata <= rdata_d;
      irq_out    <= irq_d;
      ovf_out    <= drop;
    end
  end
endmodule

// File: rtl/omsg_irq_chk.sv
module omsg_irq_chk
  import omsg_irq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             host_en,
  input logic             host_we,
  input logic [1:0]       host_sel,
  input logic [REG_W-1:0] host_rdata,
  input logic [N_MSG-1:0] loc_msg_set,
  input logic             loc_db_pend,
  input logic             loc_push,
  input logic             irq_out,
  input logic             ovf_out,
  input logic [REG_W-1:0] raw,
  input logic [REG_W-1:0] mask,
  input logic             pq_pend,
  input logic             pq_full
);
  p_set_wins_m0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    loc_msg_set[0] |=> raw[B_MSG0]);
  p_set_wins_m1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    loc_msg_set[1] |=> raw[B_MSG1]);
  p_db_mirror_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_en && !host_we && host_sel == 2'd0) |=> host_rdata[B_DB] == $past(loc_db_pend));
  p_pq_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_en && host_we && host_sel == 2'd0 && !loc_push) |=> raw[B_PQ] == $past(raw[B_PQ]));
  p_pq_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_en && !host_we && host_sel == 2'd0 && mask[B_PQ]) |=> !host_rdata[B_PQ]);
  p_reserved_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_en && !host_we && host_sel != 2'd2) |=> (host_rdata & ~EVT_BITS) == '0);
  p_empty_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_en && !host_we && host_sel == 2'd2 && !pq_pend) |=> host_rdata == '1);
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_out |-> $past(loc_push && pq_full));
  p_irq_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(raw & ~mask)) |=> irq_out);
  p_irq_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(raw & ~mask)) |=> !irq_out);
endmodule

bind omsg_irq_ctrl omsg_irq_chk u_chk (
  .clk(clk), .rst_n(rst_sn),
  .host_en(host_en), .host_we(host_we), .host_sel(host_sel), .host_rdata(host_rdata),
  .loc_msg_set(loc_msg_set), .loc_db_pend(loc_db_pend), .loc_push(loc_push),
  .irq_out(irq_out), .ovf_out(ovf_out),
  .raw(raw_stat), .mask(mask_q), .pq_pend(pq_pend), .pq_full(pq_full)
);

// File: tb/omsg_irq_ctrl_tb.sv
module omsg_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_en = 1'b0, host_we = 1'b0;
  logic [1:0]  host_sel = 2'd0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic [1:0]  loc_msg_set = '0;
  logic        loc_db_pend = 1'b0, loc_push = 1'b0;
  logic [31:0] loc_push_data = '0;
  logic        irq_out, ovf_out;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  omsg_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .host_en(host_en), .host_we(host_we),
    .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .loc_msg_set(loc_msg_set), .loc_db_pend(loc_db_pend), .loc_push(loc_push),
    .loc_push_data(loc_push_data), .irq_out(irq_out), .ovf_out(ovf_out)
  );

  // vector: kind(2) sel(2) req(4) data(32) expect(32)
  // kind 0 write, 1 read+check, 2 push, 3 message set pulse
  localparam int NV = 23;
  localparam logic [71:0] VEC [NV] = '{
    {2'd1, 2'd0, 4'd1, 32'h0,          32'h0},          // R1 status
    {2'd1, 2'd1, 4'd1, 32'h0,          32'h0},          // R1 mask
    {2'd3, 2'd0, 4'd2, 32'h1,          32'h0},          // R2 set msg0
    {2'd1, 2'd0, 4'd2, 32'h0,          32'h1},
    {2'd0, 2'd0, 4'd2, 32'h0,          32'h0},          // R2 write 0
    {2'd1, 2'd0, 4'd2, 32'h0,          32'h1},
    {2'd0, 2'd0, 4'd2, 32'h1,          32'h0},          // R2 w1c
    {2'd1, 2'd0, 4'd2, 32'h0,          32'h0},
    {2'd0, 2'd1, 4'd7, 32'hFFFF_FFFF,  32'h0},          // R7 mask all
    {2'd1, 2'd1, 4'd7, 32'h0,          32'h0000_002B},
    {2'd0, 2'd1, 4'd7, 32'h0,          32'h0},
    {2'd1, 2'd1, 4'd7, 32'h0,          32'h0},
    {2'd2, 2'd0, 4'd5, 32'hA5A5_0001,  32'h0},          // R5 push
    {2'd1, 2'd0, 4'd5, 32'h0,          32'h20},
    {2'd0, 2'd0, 4'd5, 32'h20,         32'h0},          // R5 write ignored
    {2'd1, 2'd0, 4'd5, 32'h0,          32'h20},
    {2'd0, 2'd1, 4'd6, 32'h20,         32'h0},          // R6 mask pq
    {2'd1, 2'd0, 4'd6, 32'h0,          32'h0},
    {2'd0, 2'd1, 4'd6, 32'h0,          32'h0},
    {2'd1, 2'd0, 4'd6, 32'h0,          32'h20},
    {2'd1, 2'd2, 4'd8, 32'h0,          32'hA5A5_0001},  // R8 pop
    {2'd1, 2'd0, 4'd5, 32'h0,          32'h0},          // R5 drained
    {2'd1, 2'd2, 4'd8, 32'h0,          32'hFFFF_FFFF}   // R8 empty
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    host_en = 1'b1; host_we = 1'b1; host_sel = s; host_wdata = d;
    @(negedge clk);
    host_en = 1'b0; host_we = 1'b0;
  endtask

  task automatic hread(input logic [1:0] s, input logic [31:0] exp, input string req);
    @(negedge clk);
    host_en = 1'b1; host_we = 1'b0; host_sel = s;
    @(negedge clk);
    host_en = 1'b0;
    chk(req, host_rdata, exp);
  endtask

  task automatic push(input logic [31:0] d);
    @(negedge clk);
    loc_push = 1'b1; loc_push_data = d;
    @(negedge clk);
    loc_push = 1'b0;
  endtask

  task automatic mset(input logic [1:0] m);
    @(negedge clk);
    loc_msg_set = m;
    @(negedge clk);
    loc_msg_set = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 irq", {31'd0, irq_out}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [71:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[67:64], i);
      case (v[71:70])
        2'd0: hwrite(v[69:68], v[63:32]);
        2'd1: hread(v[69:68], v[31:0], tag);
        2'd2: push(v[63:32]);
        default: mset(v[33:32]);
      endcase
    end

    // R4 doorbell mirror
    @(negedge clk); loc_db_pend = 1'b1;
    hread(2'd0, 32'h8, "R4 db high");
    hwrite(2'd0, 32'h8);
    hread(2'd0, 32'h8, "R4 write ignored");
    @(negedge clk); loc_db_pend = 1'b0;
    hread(2'd0, 32'h0, "R4 db low");

    // R3 set and clear on the same cycle
    @(negedge clk);
    loc_msg_set = 2'b10;
    host_en = 1'b1; host_we = 1'b1; host_sel = 2'd0; host_wdata = 32'h2;
    @(negedge clk);
    loc_msg_set = '0; host_en = 1'b0; host_we = 1'b0;
    hread(2'd0, 32'h2, "R3 set wins");
    hwrite(2'd0, 32'h2);
    hread(2'd0, 32'h0, "R3 later clear");

    // R10 interrupt timing
    mset(2'b01);
    chk("R10 irq not yet", {31'd0, irq_out}, 32'd0);
    @(negedge clk);
    chk("R10 irq rise", {31'd0, irq_out}, 32'd1);
    hwrite(2'd1, 32'h1);
    chk("R10 irq still", {31'd0, irq_out}, 32'd1);
    @(negedge clk);
    chk("R10 irq masked", {31'd0, irq_out}, 32'd0);
    hwrite(2'd1, 32'h0);
    hwrite(2'd0, 32'h1);
    @(negedge clk);
    chk("R10 irq cleared", {31'd0, irq_out}, 32'd0);

    // R8 / R9 fill, overflow, drain
    for (int i = 0; i < 8; i++) push(32'h100 + i);
    chk("R9 no ovf at fill", {31'd0, ovf_out}, 32'd0);
    push(32'hDEAD_BEEF);
    chk("R9 ovf pulse", {31'd0, ovf_out}, 32'd1);
    @(negedge clk);
    chk("R9 ovf one cycle", {31'd0, ovf_out}, 32'd0);
    for (int i = 0; i < 8; i++) begin
      hread(2'd2, 32'h100 + i, $sformatf("R8 order %0d", i));
      if (i == 6) hread(2'd0, 32'h20, "R5 one left");
    end
    hread(2'd0, 32'h0, "R5 empty after drain");
    hread(2'd2, 32'hFFFF_FFFF, "R8 empty again");

    // R1 reset in mid-run
    mset(2'b01);
    hwrite(2'd1, 32'h8);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 irq after reset", {31'd0, irq_out}, 32'd0);
    hread(2'd0, 32'h0, "R1 status after reset");
    hread(2'd1, 32'h0, "R1 mask after reset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule